// File: doc/BRIEF.md
# Sleep-Aware Watchdog Timer

This block is a countdown watchdog for a small microcontroller core. While enabled, a counter steps down once per clock from a start value toward zero. Software proves it is alive by pulsing the kick input, which reloads the start value. If the count reaches zero without a kick, the block raises an event. The kind of event depends on the core's state.

When the core is running, the event is a one-cycle system reset request. When the core is asleep, the event is a one-cycle wake pulse and no reset is requested, so execution resumes where it stopped. After either event the counter reloads by itself. A sticky fired flag records that a timeout happened, so software can tell a watchdog event apart from other reset causes. A kick clears the flag.

A configuration enable input turns the whole function on or off. While the enable is low, the counter is held at its start value and no event is produced. The start value must be nonzero.

Top module: `wdog_sleepwake`

## Requirements
- R1: While asynchronous reset is asserted, `sys_rst_req_o`, `wake_evt_o` and `wd_fired_o` are low and the counter holds `START_VAL`.
- R2: With enable high and no kick, the counter decreases by one per clock. The first event is visible exactly `START_VAL`+1 cycles after the cycle in which the counter was loaded.
- R3: A kick sampled while enabled reloads `START_VAL`. Kicks spaced no more than `START_VAL` cycles apart prevent any event.
- R4: When the timeout occurs with `core_asleep_i` low, `sys_rst_req_o` is high for exactly one cycle and `wake_evt_o` stays low.
- R5: When the timeout occurs with `core_asleep_i` high, `wake_evt_o` is high for exactly one cycle and `sys_rst_req_o` stays low.
- R6: After an event, the counter reloads automatically, so the next event follows `START_VAL`+1 cycles later.
- R7: With enable low, the counter is held at `START_VAL` and no event is produced. After enable rises, the first event comes `START_VAL`+1 cycles after the last cycle in which the enable was low.
- R8: `wd_fired_o` rises in the same cycle as the event pulse and stays high until a kick. It is low in the cycle after a kick is sampled, whatever the enable.
- R9: If a kick is sampled in the same cycle in which the count is zero, the kick wins. No event is produced and `wd_fired_o` is low afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| arst_n_i | input | 1 | Asynchronous reset, active low |
| wd_en_i | input | 1 | Configuration enable; 1 = watchdog runs |
| kick_i | input | 1 | Software restart pulse; reloads the counter and clears the flag |
| core_asleep_i | input | 1 | 1 while the core is in sleep |
| sys_rst_req_o | output | 1 | One-cycle reset request on a timeout while awake |
| wake_evt_o | output | 1 | One-cycle wake pulse on a timeout while asleep |
| wd_fired_o | output | 1 | Sticky timeout flag, cleared by a kick |

## Verification
The assertions depend on `START_VAL` being nonzero. Without that, the one-cycle pulse and reload properties cannot hold. They also assume that kick, enable and sleep are synchronous, single-bit levels that are stable around the clock edge. The stimulus meets these assumptions by changing every input only on the falling edge, using a small start value. The sleep flag is set well before the cycle in which the count reaches zero, so that cycle alone decides the kind of event.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    EVT_NONE  = 2'd0,
    EVT_RESET = 2'd1,
    EVT_WAKE  = 2'd2
  } wd_evt_e;

  // Pick the action for a cycle given whether the count expired and
  // whether the core is sleeping.
  function automatic wd_evt_e classify(input logic expired, input logic asleep);
    if (!expired) return EVT_NONE;
    return asleep ? EVT_WAKE : EVT_RESET;
  endfunction

endpackage

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned       CNT_W     = 16,
  parameter logic [CNT_W-1:0]  START_VAL = {CNT_W{1'b1}}
) (
  input  logic             clk_i,
  input  logic             arst_n_i,
  input  logic             en_i,
  input  logic             kick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);

  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] ZERO = '0;

  function automatic logic [CNT_W-1:0] dec_count(input logic [CNT_W-1:0] c);
    return c - ONE;
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             at_zero;

  assign at_zero  = (cnt_q == ZERO);
  // A kick in the zero cycle suppresses the expiry (R9).
  assign expire_o = en_i & ~kick_i & at_zero;

  always_comb begin
    if (!en_i)              cnt_d = START_VAL;
    else if (kick_i)        cnt_d = START_VAL;
    else if (at_zero)       cnt_d = START_VAL;
    else                    cnt_d = dec_count(cnt_q);
  end

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) cnt_q <= START_VAL;
    else           cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  AST_COUNT_STEPS_DOWN: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    (en_i && !kick_i && cnt_q != ZERO) |=> (cnt_q == dec_count($past(cnt_q)))); // R2
  AST_KICK_RELOADS: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    (en_i && kick_i) |=> (cnt_q == START_VAL)); // R3
  AST_AUTO_RELOAD: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    expire_o |=> (cnt_q == START_VAL)); // R6
  AST_DISABLED_HOLDS: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    !en_i |=> (cnt_q == START_VAL)); // R7

endmodule

// File: rtl/wdog_event.sv
module wdog_event
  import wdog_pkg::*;
(
  input  logic clk_i,
  input  logic arst_n_i,
  input  logic expire_i,
  input  logic asleep_i,
  output logic rst_req_o,
  output logic wake_o
);

  wd_evt_e evt;
  logic    rst_q;
  logic    wake_q;

  assign evt = classify(expire_i, asleep_i);

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) begin
      rst_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      rst_q  <= (evt == EVT_RESET);
      wake_q <= (evt == EVT_WAKE);
    end
  end

  assign rst_req_o = rst_q;
  assign wake_o    = wake_q;

  AST_AWAKE_GIVES_RESET: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    (expire_i && !asleep_i) |=> (rst_req_o && !wake_o)); // R4
  AST_ASLEEP_GIVES_WAKE: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    (expire_i && asleep_i) |=> (wake_o && !rst_req_o)); // R5
  AST_RESET_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    rst_req_o |=> !rst_req_o); // R4
  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    wake_o |=> !wake_o); // R5
  AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    $onehot0({rst_req_o, wake_o})); // R5

endmodule

// File: rtl/wdog_status.sv
module wdog_status (
  input  logic clk_i,
  input  logic arst_n_i,
  input  logic expire_i,
  input  logic kick_i,
  output logic fired_o
);

  logic fired_q;

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i)     fired_q <= 1'b0;
    else if (kick_i)   fired_q <= 1'b0;
    else if (expire_i) fired_q <= 1'b1;
  end

  assign fired_o = fired_q;

  AST_FLAG_SETS: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    expire_i |=> fired_o); // R8
  AST_FLAG_CLEARS: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    kick_i |=> !fired_o); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    (fired_o && !kick_i) |=> fired_o); // R8

endmodule

// File: rtl/wdog_sleepwake.sv
module wdog_sleepwake #(
  parameter int unsigned      CNT_W     = 16,
  parameter logic [CNT_W-1:0] START_VAL = {CNT_W{1'b1}}
) (
  input  logic clk_i,
  input  logic arst_n_i,
  input  logic wd_en_i,
  input  logic kick_i,
  input  logic core_asleep_i,
  output logic sys_rst_req_o,
  output logic wake_evt_o,
  output logic wd_fired_o
);

  // Internal events brought out as named wires.
  logic [CNT_W-1:0] cnt;
  logic             expire;

  wdog_counter #(
    .CNT_W     (CNT_W),
    .START_VAL (START_VAL)
  ) u_counter (
    .clk_i    (clk_i),
    .arst_n_i (arst_n_i),
    .en_i     (wd_en_i),
    .kick_i   (kick_i),
    .cnt_o    (cnt),
    .expire_o (expire)
  );

  wdog_event u_event (
    .clk_i     (clk_i),
    .arst_n_i  (arst_n_i),
    .expire_i  (expire),
    .asleep_i  (core_asleep_i),
    .rst_req_o (sys_rst_req_o),
    .wake_o    (wake_evt_o)
  );

  wdog_status u_status (
    .clk_i    (clk_i),
    .arst_n_i (arst_n_i),
    .expire_i (expire),
    .kick_i   (kick_i),
    .fired_o  (wd_fired_o)
  );

  always_comb begin
    if (!arst_n_i) begin
      AST_RESET_QUIET: assert (!sys_rst_req_o && !wake_evt_o && !wd_fired_o); // R1
    end
  end

  AST_DISABLED_SILENT: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    !wd_en_i |=> !(sys_rst_req_o || wake_evt_o)); // R7
  AST_KICK_BEATS_ZERO: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    kick_i |=> !(sys_rst_req_o || wake_evt_o)); // R9
  AST_PULSE_WITH_FLAG: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    (sys_rst_req_o || wake_evt_o) |-> wd_fired_o); // R8
  AST_ZERO_ONLY_WHEN_COUNTED: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    $rose(expire) |-> $past(wd_en_i)); // R2

endmodule

// File: tb/wdog_sleepwake_tb.sv
module wdog_sleepwake_tb;

  localparam int unsigned W = 8;
  localparam int          S = 12;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic en = 1'b1;
  logic kick = 1'b0;
  logic asleep = 1'b0;
  logic rst_req, wake, fired;

  wdog_sleepwake #(
    .CNT_W     (W),
    .START_VAL (W'(S))
  ) u_dut (
    .clk_i         (clk),
    .arst_n_i      (arst_n),
    .wd_en_i       (en),
    .kick_i        (kick),
    .core_asleep_i (asleep),
    .sys_rst_req_o (rst_req),
    .wake_evt_o    (wake),
    .wd_fired_o    (fired)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int at; bit is_wake; } exp_t;
  exp_t q[$];

  int checks = 0;
  int fails = 0;
  int load_cyc = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Monitor: every observed pulse must match the head of the queue.
  always @(negedge clk) begin
    if (arst_n && !done && (rst_req || wake)) begin
      if (q.size() == 0) begin
        check(1'b0, "R9", "unexpected event at cycle", cyc, -1);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(e.at == cyc, e.is_wake ? "R5" : "R4", "event cycle", cyc, e.at);
        check((wake == e.is_wake) && (rst_req == !e.is_wake),
              e.is_wake ? "R5" : "R4", "event kind wake", int'(wake), int'(e.is_wake));
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: predict the next timeout and wait for it.
  task automatic expect_timeout(input bit slp, input string req);
    exp_t e;
    asleep = slp;
    e.at = load_cyc + S + 1;
    e.is_wake = slp;
    q.push_back(e);
    while (cyc < e.at) @(negedge clk);
    load_cyc = e.at;
    check(fired == 1'b1, req, "flag after timeout (R8)", int'(fired), 1);
  endtask

  task automatic do_kick;
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    load_cyc = cyc;
  endtask

  initial begin
    step(3);
    check(!rst_req && !wake && !fired, "R1", "outputs in reset",
          int'({rst_req, wake, fired}), 0);
    arst_n = 1'b1;
    load_cyc = cyc;
    step(1);
    check(!rst_req && !wake && !fired, "R1", "outputs after release",
          int'({rst_req, wake, fired}), 0);

    expect_timeout(1'b0, "R2");
    expect_timeout(1'b0, "R6");

    do_kick;
    check(fired == 1'b0, "R8", "flag after kick", int'(fired), 0);

    expect_timeout(1'b1, "R5");

    do_kick;
    for (int i = 0; i < 5; i++) begin
      step(S - 1);
      do_kick;
    end
    check(fired == 1'b0 && q.size() == 0, "R3", "no event with regular kicks",
          int'(fired) + q.size(), 0);

    // Kick exactly in the zero cycle.
    while (cyc < load_cyc + S) @(negedge clk);
    do_kick;
    step(2);
    check(fired == 1'b0, "R9", "flag after colliding kick", int'(fired), 0);
    check(q.size() == 0, "R9", "pending events", q.size(), 0);

    // Set the flag, then disable for a long stretch.
    expect_timeout(1'b0, "R4");
    en = 1'b0;
    step(3 * S);
    check(fired == 1'b1, "R7", "flag held while disabled", int'(fired), 1);
    en = 1'b1;
    load_cyc = cyc;
    expect_timeout(1'b0, "R7");

    expect_timeout(1'b1, "R5");
    expect_timeout(1'b0, "R4");

    step(2);
    done = 1'b1;
    check(q.size() == 0, "R2", "events left unobserved", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule